// File: doc/BRIEF.md
# Converter Configuration and Result Port

This block is the host side of a data converter's 10-bit parallel port. On a write cycle the host places a word on the bus. The two most significant bits choose a configuration register and the eight bits below them become that register's new contents. Two registers exist. Control register A holds the calibration mode, the clock source, the input type, the conversion mode and the channel. Control register B holds the start source, the resolution, the number format and the two power-down controls. The decoded fields are brought out as separate outputs for the conversion sequencer.

On a read cycle the block places the latest conversion code on the bus. The code is MSB-aligned for the programmed resolution, and the unused low bits are zero. The code is given either as offset binary or as two's complement. The bus is modelled as separate `bus_in`, `bus_out` and `bus_oe` signals. The pad three-states whenever `bus_oe` is low.

The strobes and the write data are asynchronous to the system clock, so they are synchronised first. A small write state machine then commits the captured word. Its states are:
- `WS_IDLE` moves to `WS_STROBE` when the synchronised chip select and write strobe are both low.
- `WS_STROBE` captures the synchronised data on every cycle.
- `WS_STROBE` returns to `WS_IDLE` if chip select rises first. This is an abort.
- `WS_STROBE` moves to `WS_COMMIT` when the write strobe rises while chip select is still low.
- `WS_COMMIT` stores the captured word into the indexed register. It always returns to `WS_IDLE` on the next cycle.

Top module: `adc_cfg_port`

## Requirements
- R1: After reset every configuration output is zero. This means calibrated operation, internal clock, single-ended input, mono interrupt mode, channel 1, read-strobe start, 10-bit resolution, two's-complement output and no power-down.
- R2: A write with index 2'b00 in bus bits 9:8 loads control register A from bits 7:0. The layout is `cal_mode`=[7:6], `clk_ext`=[5], `diff_in`=[4], `conv_mode`=[3:2] and `chan_sel`=[1:0].
- R3: A write with index 2'b01 loads control register B. The layout is `start_pin_sel`=[6], `res_sel`=[5:4], `fmt_bin`=[2], `auto_pd_en`=[1] and `sw_pd`=[0]. Bits 7 and 3 are reserved and are stored as zero.
- R4: Writes with index 2'b10 or 2'b11 change no configuration output.
- R5: A write takes effect only on a rising write strobe while chip select is low. A write strobe pulse with chip select high does nothing, and so does a cycle in which chip select rises before the write strobe.
- R6: `bus_oe` is high only while `cs_n` and `rd_n` are both low. When `bus_oe` is low, `bus_out` is zero.
- R7: At 10-bit resolution (`res_sel`=2'b00), `conv_code[9:0]` appears on bus bits 9:0.
- R8: At 8-bit resolution (`res_sel`=2'b10), `conv_code[7:0]` appears on bits 9:2 and bits 1:0 read zero.
- R9: At 4-bit resolution (`res_sel`=2'b01), `conv_code[3:0]` appears on bits 9:6 and bits 5:0 read zero.
- R10: With `fmt_bin`=1 the code is passed as offset binary. With `fmt_bin`=0 the MSB of the code at the active resolution is inverted before alignment.
- R11: The test resolution setting (`res_sel`=2'b11) aligns the result like the 10-bit setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 10 | Data bus as seen from the pad (host write data) |
| bus_out | output | 10 | Read data driven toward the pad |
| bus_oe | output | 1 | Pad output enable; bus three-stated when low |
| conv_code | input | 10 | Right-justified conversion code from the converter core |
| cal_mode | output | 2 | Offset calibration mode |
| clk_ext | output | 1 | 1 selects the external conversion clock |
| diff_in | output | 1 | 1 selects differential inputs |
| conv_mode | output | 2 | Conversion mode (mono/dual, interrupt/continuous) |
| chan_sel | output | 2 | Channel select |
| start_pin_sel | output | 1 | 1 starts interrupt-mode conversions from the start pin |
| res_sel | output | 2 | Resolution code |
| fmt_bin | output | 1 | 1 selects offset binary, 0 selects two's complement |
| auto_pd_en | output | 1 | Automatic power-down enable |
| sw_pd | output | 1 | Software power-down |

## Verification
The write-path properties assume the host holds `bus_in` stable from the falling edge of the write strobe until several clock cycles after its rising edge. They also assume the strobe stays low for more cycles than the synchroniser depth. The bench keeps the strobe low for four cycles and holds the data for six cycles after release, so every captured word is settled. The read-path checks assume `conv_code` and the configuration are steady while the read strobe is low. The bench therefore changes the code only between reads and samples two time units after asserting the strobes.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

    localparam int BUS_W  = 10;
    localparam int IDX_W  = 2;
    localparam int REG_W  = BUS_W - IDX_W;
    localparam int SYNC_N = 2;

    localparam logic [IDX_W-1:0] IDX_CTL_A = 2'b00;
    localparam logic [IDX_W-1:0] IDX_CTL_B = 2'b01;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'b00,
        WS_STROBE = 2'b01,
        WS_COMMIT = 2'b10
    } wr_state_e;

    typedef enum logic [1:0] {
        RES_10   = 2'b00,
        RES_4    = 2'b01,
        RES_8    = 2'b10,
        RES_TEST = 2'b11
    } res_e;

    typedef struct packed {
        logic [1:0] cal;
        logic       clk_ext;
        logic       diff;
        logic [1:0] mode;
        logic [1:0] chan;
    } ctl_a_t;

    typedef struct packed {
        logic       rsv_hi;
        logic       start_pin;
        logic [1:0] res;
        logic       rsv_lo;
        logic       fmt_bin;
        logic       auto_pd;
        logic       sw_pd;
    } ctl_b_t;

    localparam logic [REG_W-1:0] CTL_B_MASK = 8'b0111_0111;

endpackage

// File: rtl/adc_cfg_sync.sv
module adc_cfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_cfg_wr_fsm.sv
module adc_cfg_wr_fsm
    import adc_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             wr_s,
    input  logic [BUS_W-1:0] data_s,
    output ctl_a_t           cfg_a,
    output ctl_b_t           cfg_b
);

    wr_state_e        state, state_nxt;
    logic [BUS_W-1:0] hold;
    logic             do_capture;
    logic             do_commit;
    logic [IDX_W-1:0] hold_idx;
    logic [REG_W-1:0] hold_val;

    assign hold_idx = hold[BUS_W-1 -: IDX_W];
    assign hold_val = hold[REG_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nxt;
    end

    // next state and per-state controls
    always_comb begin
        state_nxt  = state;
        do_capture = 1'b0;
        do_commit  = 1'b0;
        unique case (state)
            WS_IDLE: begin
                if (!cs_s && !wr_s) state_nxt = WS_STROBE;
            end
            WS_STROBE: begin
                do_capture = 1'b1;
                if (cs_s)       state_nxt = WS_IDLE;
                else if (wr_s)  state_nxt = WS_COMMIT;
            end
            WS_COMMIT: begin
                do_commit = 1'b1;
                state_nxt = WS_IDLE;
            end
            default: state_nxt = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold  <= '0;
            cfg_a <= '0;
            cfg_b <= '0;
        end else begin
            if (do_capture) hold <= data_s;
            if (do_commit) begin
                if (hold_idx == IDX_CTL_A) cfg_a <= ctl_a_t'(hold_val);
                if (hold_idx == IDX_CTL_B) cfg_b <= ctl_b_t'(hold_val & CTL_B_MASK);
            end
        end
    end

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == WS_COMMIT |=> state == WS_IDLE); // R5
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state != WS_COMMIT |=> ($stable(cfg_a) && $stable(cfg_b))); // R5
    AST_ARM_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_IDLE && cs_s) |=> state == WS_IDLE); // R5
    AST_HIGH_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_COMMIT && hold_idx[IDX_W-1]) |=> ($stable(cfg_a) && $stable(cfg_b))); // R4

endmodule

// File: rtl/adc_cfg_rd_fmt.sv
module adc_cfg_rd_fmt
    import adc_cfg_pkg::*;
(
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic [1:0]       res,
    input  logic             fmt_bin,
    input  logic [BUS_W-1:0] code,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe
);

    localparam int PAD8 = BUS_W - 8;
    localparam int PAD4 = BUS_W - 4;

    logic [BUS_W-1:0] word;
    logic [7:0]       c8;
    logic [3:0]       c4;
    logic [BUS_W-1:0] cf;

    always_comb begin
        c8 = code[7:0];
        c4 = code[3:0];
        cf = code;
        if (!fmt_bin) begin
            c8[7]       = ~c8[7];
            c4[3]       = ~c4[3];
            cf[BUS_W-1] = ~cf[BUS_W-1];
        end
        unique case (res_e'(res))
            RES_8:   word = {c8, {PAD8{1'b0}}};
            RES_4:   word = {c4, {PAD4{1'b0}}};
            default: word = cf;
        endcase
    end

    assign bus_oe  = !cs_n && !rd_n;
    assign bus_out = bus_oe ? word : '0;

    always_comb begin
        if (bus_oe && res == RES_8)
            AST_R8_LOW_ZERO: assert (bus_out[PAD8-1:0] == '0); // R8
        if (bus_oe && res == RES_4)
            AST_R4_LOW_ZERO: assert (bus_out[PAD4-1:0] == '0); // R9
    end

endmodule

// File: rtl/adc_cfg_port.sv
module adc_cfg_port
    import adc_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] conv_code,
    output logic [1:0]       cal_mode,
    output logic             clk_ext,
    output logic             diff_in,
    output logic [1:0]       conv_mode,
    output logic [1:0]       chan_sel,
    output logic             start_pin_sel,
    output logic [1:0]       res_sel,
    output logic             fmt_bin,
    output logic             auto_pd_en,
    output logic             sw_pd
);

    logic [1:0]       strb_s;
    logic [BUS_W-1:0] data_s;
    ctl_a_t           cfg_a;
    ctl_b_t           cfg_b;

    adc_cfg_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b11)) u_strb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, wr_n}),
        .q     (strb_s)
    );

    adc_cfg_sync #(.W(BUS_W), .STAGES(SYNC_N), .RST_VAL('0)) u_data_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (data_s)
    );

    adc_cfg_wr_fsm u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_s   (strb_s[1]),
        .wr_s   (strb_s[0]),
        .data_s (data_s),
        .cfg_a  (cfg_a),
        .cfg_b  (cfg_b)
    );

    adc_cfg_rd_fmt u_rd (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .res     (cfg_b.res),
        .fmt_bin (cfg_b.fmt_bin),
        .code    (conv_code),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    assign cal_mode      = cfg_a.cal;
    assign clk_ext       = cfg_a.clk_ext;
    assign diff_in       = cfg_a.diff;
    assign conv_mode     = cfg_a.mode;
    assign chan_sel      = cfg_a.chan;
    assign start_pin_sel = cfg_b.start_pin;
    assign res_sel       = cfg_b.res;
    assign fmt_bin       = cfg_b.fmt_bin;
    assign auto_pd_en    = cfg_b.auto_pd;
    assign sw_pd         = cfg_b.sw_pd;

endmodule

// File: tb/tb_adc_cfg_port.sv
module tb_adc_cfg_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [9:0] bus_in = '0;
    logic [9:0] conv_code = '0;
    logic [9:0] bus_out;
    logic       bus_oe;
    logic [1:0] cal_mode, conv_mode, chan_sel, res_sel;
    logic       clk_ext, diff_in, start_pin_sel, fmt_bin, auto_pd_en, sw_pd;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .conv_code(conv_code),
        .cal_mode(cal_mode), .clk_ext(clk_ext), .diff_in(diff_in), .conv_mode(conv_mode),
        .chan_sel(chan_sel), .start_pin_sel(start_pin_sel), .res_sel(res_sel),
        .fmt_bin(fmt_bin), .auto_pd_en(auto_pd_en), .sw_pd(sw_pd)
    );

    // {res[1:0], fmt, code[9:0], expected bus[9:0]}
    localparam logic [22:0] VEC [8] = '{
        {2'b00, 1'b1, 10'h2A5, 10'h2A5},   // R7
        {2'b00, 1'b0, 10'h2A5, 10'h0A5},   // R10
        {2'b10, 1'b1, 10'h0B7, 10'h2DC},   // R8
        {2'b10, 1'b0, 10'h0B7, 10'h0DC},   // R10
        {2'b01, 1'b1, 10'h009, 10'h240},   // R9
        {2'b01, 1'b0, 10'h009, 10'h040},   // R10
        {2'b11, 1'b1, 10'h155, 10'h155},   // R11
        {2'b10, 1'b1, 10'h3FF, 10'h3FC}    // R8
    };

    function automatic logic [7:0] cfg_a_vec();
        return {cal_mode, clk_ext, diff_in, conv_mode, chan_sel};
    endfunction

    function automatic logic [7:0] cfg_b_vec();
        return {1'b0, start_pin_sel, res_sel, 1'b0, fmt_bin, auto_pd_en, sw_pd};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [9:0] w, input logic use_cs);
        @(negedge clk);
        cs_n = !use_cs;
        bus_in = w;
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_read(input string req, input logic [9:0] exp);
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b0;
        #2;
        check(req, {31'd0, bus_oe}, 32'd1);
        check(req, {22'd0, bus_out}, {22'd0, exp});
        @(negedge clk);
        rd_n = 1'b1;
        cs_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a_snap, b_snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cfg_a", {24'd0, cfg_a_vec()}, 32'd0);
        check("R1 cfg_b", {24'd0, cfg_b_vec()}, 32'd0);
        check("R1 bus_oe", {31'd0, bus_oe}, 32'd0);

        // R2 control register A, two patterns
        host_write({2'b00, 8'b10_1_1_10_11}, 1'b1);
        check("R2 pattern1", {24'd0, cfg_a_vec()}, {24'd0, 8'b10_1_1_10_11});
        host_write({2'b00, 8'b01_0_1_01_10}, 1'b1);
        check("R2 pattern2", {24'd0, cfg_a_vec()}, {24'd0, 8'b01_0_1_01_10});
        check("R2 cfg_b untouched", {24'd0, cfg_b_vec()}, 32'd0);

        // R3 reserved bits dropped
        host_write({2'b01, 8'hFF}, 1'b1);
        check("R3 reserved", {24'd0, cfg_b_vec()}, {24'd0, 8'h77});

        // Vector table: R3 fields plus R7..R11 alignment and format
        for (int i = 0; i < 8; i++) begin
            logic [7:0] wb;
            wb = {1'b0, i[0], VEC[i][22:21], 1'b0, VEC[i][20], i[1], i[2]};
            host_write({2'b01, wb}, 1'b1);
            check("R3 cfg_b", {24'd0, cfg_b_vec()}, {24'd0, wb});
            conv_code = VEC[i][19:10];
            host_read("R7-11 vector", VEC[i][9:0]);
        end

        // R6 bus enable
        conv_code = 10'h3FF;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1; #2;
        check("R6 cs only oe", {31'd0, bus_oe}, 32'd0);
        check("R6 cs only data", {22'd0, bus_out}, 32'd0);
        cs_n = 1'b1; rd_n = 1'b0; #2;
        check("R6 rd only oe", {31'd0, bus_oe}, 32'd0);
        cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0; #2;
        check("R6 write cycle oe", {31'd0, bus_oe}, 32'd0);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 high indexes ignored
        a_snap = cfg_a_vec();
        b_snap = cfg_b_vec();
        host_write({2'b10, 8'h00}, 1'b1);
        check("R4 idx10 a", {24'd0, cfg_a_vec()}, {24'd0, a_snap});
        check("R4 idx10 b", {24'd0, cfg_b_vec()}, {24'd0, b_snap});
        host_write({2'b11, 8'hA5}, 1'b1);
        check("R4 idx11 a", {24'd0, cfg_a_vec()}, {24'd0, a_snap});
        check("R4 idx11 b", {24'd0, cfg_b_vec()}, {24'd0, b_snap});

        // R5 write strobe without chip select
        host_write({2'b00, 8'h00}, 1'b0);
        check("R5 no cs", {24'd0, cfg_a_vec()}, {24'd0, a_snap});

        // R5 chip select released before write strobe
        @(negedge clk);
        cs_n = 1'b0; bus_in = {2'b00, 8'h3C}; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R5 abort", {24'd0, cfg_a_vec()}, {24'd0, a_snap});

        // R5 a proper write still lands afterwards
        host_write({2'b00, 8'h3C}, 1'b1);
        check("R5 recovery", {24'd0, cfg_a_vec()}, 32'h3C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule